// File: doc/BRIEF.md
# Byte-Lane DAC Level Scatter Register Bank

This block holds an 8-bit output level for each pin of a bank of analog outputs, 64 pins by default. Each pin's level goes to that pin's DAC. A single command updates the bank. The command carries a 32-bit word made of four byte lanes and a selector. The selector's upper field picks a write pattern, and its lower field picks the target pin. The patterns are:

- one lane to one pin;
- two lanes to an aligned pair of pins;
- all four lanes to an aligned group of four pins;
- an inverted lane to one pin, which serves AC-style outputs.

Packed sample data can therefore drive several neighbouring DACs with one command.

A build parameter selects a second decoding, made for single pins only. In that decoding, the top selector bit inverts the data and the next two bits choose the lane. Any pin's current level can be read back combinationally through a separate read port.

Top module: `dac_lane_scatter`

## Requirements
- R1: The pin index is cmd_sel[5:0]. The write pattern ("mode") is cmd_sel[8:6]. A command is taken on a rising clock edge where cmd_valid is 1.
- R2: With ALT_DECODE=0, modes 0 to 3 write byte lane k (cmd_data[8k+7:8k], where k is the mode number) into the addressed pin only.
- R3: With ALT_DECODE=0, mode 4 writes lane 0 to pin {cmd_sel[5:1],0} and lane 1 to pin {cmd_sel[5:1],1}. cmd_sel[0] has no effect.
- R4: With ALT_DECODE=0, mode 5 writes lane 2 to pin {cmd_sel[5:1],0} and lane 3 to pin {cmd_sel[5:1],1}. cmd_sel[0] has no effect.
- R5: With ALT_DECODE=0, mode 6 writes lane j to pin {cmd_sel[5:2],j} for j = 0 to 3. cmd_sel[1:0] have no effect.
- R6: With ALT_DECODE=0, mode 7 writes the bitwise inverse of lane 0 into the addressed pin.
- R7: With ALT_DECODE=1, every mode writes one pin. The value is lane cmd_sel[7:6], inverted bitwise when cmd_sel[8] is 1.
- R8: All pins written by one command change on the same clock edge. Pins outside the addressed group keep their levels.
- R9: No level changes in a cycle without cmd_valid.
- R10: All levels are 0 after reset.
- R11: rd_level shows the level of pin rd_pin combinationally, with no clock needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_data | input | 32 | Four byte lanes of level data |
| cmd_sel | input | 9 | Mode field [8:6] and pin index [5:0] |
| rd_pin | input | 6 | Pin whose level is read |
| rd_level | output | 8 | Current level of rd_pin |

## Verification
On every cycle, the assertions check that levels stay constant without a command and that levels are zero when reset releases. Each time a command is taken, they also check the landing value for a sample pin of each write pattern: the single lane, the odd pin of a pair, the top pin of a group of four, the inverted lane, and the alternate decoding. Only the bench's sweeps show the rest. Those sweeps cover every mode at every pin index. After each command the bench reads all 64 pins back, which shows that no pin outside the addressed group was disturbed and that the ignored low selector bits really have no effect.

// File: rtl/dac_scatter_pkg.sv
package dac_scatter_pkg;
    localparam int LANE_W  = 8;
    localparam int LANES   = 4;
    localparam int DATA_W  = LANE_W * LANES;
    localparam int MODE_W  = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_LANE0 = 3'd0,
        MODE_LANE1 = 3'd1,
        MODE_LANE2 = 3'd2,
        MODE_LANE3 = 3'd3,
        MODE_PAIR_LO = 3'd4,
        MODE_PAIR_HI = 3'd5,
        MODE_QUAD  = 3'd6,
        MODE_INV0  = 3'd7
    } mode_e;

    typedef struct packed {
        logic              en;
        logic [LANE_W-1:0] value;
    } slot_t;
endpackage

// File: rtl/dac_scatter_decode.sv
module dac_scatter_decode
    import dac_scatter_pkg::*;
#(
    parameter int NUM_PINS   = 64,
    parameter bit ALT_DECODE = 1'b0,
    localparam int PIN_W     = $clog2(NUM_PINS),
    localparam int SEL_W     = PIN_W + MODE_W
) (
    input  logic [DATA_W-1:0]          data,
    input  logic [SEL_W-1:0]           sel,
    output slot_t [LANES-1:0]          slot,
    output logic [LANES-1:0][PIN_W-1:0] slot_pin
);
    logic [PIN_W-1:0]              pin;
    logic [MODE_W-1:0]             mode;
    logic [LANES-1:0][LANE_W-1:0]  lane;

    assign pin  = sel[PIN_W-1:0];
    assign mode = sel[SEL_W-1:PIN_W];
    assign lane = data;

    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            slot[k]     = '0;
            slot_pin[k] = pin;
        end
        if (ALT_DECODE) begin
            slot[0].en    = 1'b1;
            slot[0].value = lane[mode[1:0]] ^ {LANE_W{mode[2]}};
        end else begin
            case (mode_e'(mode))
                MODE_LANE0, MODE_LANE1, MODE_LANE2, MODE_LANE3: begin
                    slot[0].en    = 1'b1;
                    slot[0].value = lane[mode[1:0]];
                end
                MODE_PAIR_LO, MODE_PAIR_HI: begin
                    for (int k = 0; k < 2; k++) begin
                        slot[k].en    = 1'b1;
                        slot[k].value = lane[{mode[0], 1'(k)}];
                        slot_pin[k]   = {pin[PIN_W-1:1], 1'(k)};
                    end
                end
                MODE_QUAD: begin
                    for (int k = 0; k < LANES; k++) begin
                        slot[k].en    = 1'b1;
                        slot[k].value = lane[k];
                        slot_pin[k]   = {pin[PIN_W-1:2], 2'(k)};
                    end
                end
                default: begin
                    slot[0].en    = 1'b1;
                    slot[0].value = ~lane[0];
                end
            endcase
        end
    end
endmodule

// File: rtl/dac_level_bank.sv
module dac_level_bank
    import dac_scatter_pkg::*;
#(
    parameter int NUM_PINS = 64,
    localparam int PIN_W   = $clog2(NUM_PINS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  slot_t [LANES-1:0]                 slot,
    input  logic [LANES-1:0][PIN_W-1:0]       slot_pin,
    output logic [NUM_PINS-1:0][LANE_W-1:0]   levels
);
    typedef struct packed {
        logic [NUM_PINS-1:0][LANE_W-1:0] lvl;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            for (int k = 0; k < LANES; k++) begin
                if (slot[k].en) begin
                    bank_d.lvl[slot_pin[k]] = slot[k].value;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign levels = bank_q.lvl;
endmodule

// File: rtl/dac_lane_scatter.sv
module dac_lane_scatter
    import dac_scatter_pkg::*;
#(
    parameter int NUM_PINS   = 64,
    parameter bit ALT_DECODE = 1'b0,
    localparam int PIN_W     = $clog2(NUM_PINS),
    localparam int SEL_W     = PIN_W + MODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [SEL_W-1:0]  cmd_sel,
    input  logic [PIN_W-1:0]  rd_pin,
    output logic [LANE_W-1:0] rd_level
);
    slot_t [LANES-1:0]               slot;
    logic [LANES-1:0][PIN_W-1:0]     slot_pin;
    logic [NUM_PINS-1:0][LANE_W-1:0] level_bus;

    dac_scatter_decode #(
        .NUM_PINS   (NUM_PINS),
        .ALT_DECODE (ALT_DECODE)
    ) decode_i (
        .data     (cmd_data),
        .sel      (cmd_sel),
        .slot     (slot),
        .slot_pin (slot_pin)
    );

    dac_level_bank #(
        .NUM_PINS (NUM_PINS)
    ) bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cmd_valid),
        .slot     (slot),
        .slot_pin (slot_pin),
        .levels   (level_bus)
    );

    assign rd_level = level_bus[rd_pin];
endmodule

// File: rtl/dac_lane_scatter_chk.sv
module dac_lane_scatter_chk
    import dac_scatter_pkg::*;
#(
    parameter int NUM_PINS   = 64,
    parameter bit ALT_DECODE = 1'b0,
    localparam int PIN_W     = $clog2(NUM_PINS),
    localparam int SEL_W     = PIN_W + MODE_W
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            cmd_valid,
    input logic [DATA_W-1:0]               cmd_data,
    input logic [SEL_W-1:0]                cmd_sel,
    input logic [NUM_PINS-1:0][LANE_W-1:0] levels
);
    logic [MODE_W-1:0] mode;
    logic [PIN_W-1:0]  pin;
    assign mode = cmd_sel[SEL_W-1:PIN_W];
    assign pin  = cmd_sel[PIN_W-1:0];

    assert_reset_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (levels == '0));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(levels));

    if (ALT_DECODE) begin : g_alt
        assert_alt_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
            cmd_valid |=> levels[$past(pin)] ==
                ($past(cmd_data[8*mode[1:0] +: 8]) ^ {LANE_W{$past(mode[2])}}));
    end else begin : g_std
        assert_single_lane0_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid && mode == 3'd0) |=> levels[$past(pin)] == $past(cmd_data[7:0]));
        assert_pair_odd_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid && mode == 3'd4) |=>
                levels[{$past(pin[PIN_W-1:1]), 1'b1}] == $past(cmd_data[15:8]));
        assert_pair_even_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid && mode == 3'd5) |=>
                levels[{$past(pin[PIN_W-1:1]), 1'b0}] == $past(cmd_data[23:16]));
        assert_quad_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid && mode == 3'd6) |=>
                levels[{$past(pin[PIN_W-1:2]), 2'b11}] == $past(cmd_data[31:24]));
        assert_inverted_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid && mode == 3'd7) |=> levels[$past(pin)] == ~$past(cmd_data[7:0]));
    end
endmodule

bind dac_lane_scatter dac_lane_scatter_chk #(
    .NUM_PINS   (NUM_PINS),
    .ALT_DECODE (ALT_DECODE)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_data  (cmd_data),
    .cmd_sel   (cmd_sel),
    .levels    (level_bus)
);

// File: tb/dac_lane_scatter_tb_top.sv
`timescale 1ns/1ps
module dac_lane_scatter_tb_top;
    localparam int NP = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [31:0] cmd_data = '0;
    logic [8:0]  cmd_sel = '0;
    logic [5:0]  rd_pin = '0;
    logic [7:0]  rd_std, rd_alt;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    logic [7:0] exp_std [NP];
    logic [7:0] exp_alt [NP];

    always #5 clk = ~clk;

    dac_lane_scatter #(.NUM_PINS(NP), .ALT_DECODE(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
        .cmd_sel(cmd_sel), .rd_pin(rd_pin), .rd_level(rd_std));

    dac_lane_scatter #(.NUM_PINS(NP), .ALT_DECODE(1'b1)) dut_alt_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
        .cmd_sel(cmd_sel), .rd_pin(rd_pin), .rd_level(rd_alt));

    function automatic logic [7:0] lane_of(logic [31:0] d, int k);
        return d[8*k +: 8];
    endfunction

    // Model of R2..R7; R1 field layout: sel = {mode, pin}
    task automatic model_apply(int mode, int pin, logic [31:0] d);
        exp_alt[pin] = lane_of(d, mode % 4) ^ ((mode >= 4) ? 8'hFF : 8'h00);
        case (mode)
            0, 1, 2, 3: exp_std[pin] = lane_of(d, mode);
            4: begin
                exp_std[pin - pin % 2]     = lane_of(d, 0);
                exp_std[pin - pin % 2 + 1] = lane_of(d, 1);
            end
            5: begin
                exp_std[pin - pin % 2]     = lane_of(d, 2);
                exp_std[pin - pin % 2 + 1] = lane_of(d, 3);
            end
            6: for (int j = 0; j < 4; j++) exp_std[pin - pin % 4 + j] = lane_of(d, j);
            default: exp_std[pin] = ~lane_of(d, 0);
        endcase
    endtask

    function automatic string tag_of(int mode);
        case (mode)
            0, 1, 2, 3: return "R2";
            4: return "R3";
            5: return "R4";
            6: return "R5";
            default: return "R6";
        endcase
    endfunction

    // R11: rd_pin changes and rd_level is sampled 1 ns later, no edge needed.
    // R8/R9: every pin is compared after each command while cmd_valid stays low.
    task automatic check_all(string tag_std, string tag_alt);
        for (int p = 0; p < NP; p++) begin
            rd_pin = 6'(p);
            #1;
            compared++;
            if (rd_std !== exp_std[p]) begin
                mismatched++;
                $display("FAIL %s/R8/R11 std pin %0d got %h exp %h", tag_std, p, rd_std, exp_std[p]);
            end
            compared++;
            if (rd_alt !== exp_alt[p]) begin
                mismatched++;
                $display("FAIL %s/R8/R11 alt pin %0d got %h exp %h", tag_alt, p, rd_alt, exp_alt[p]);
            end
        end
    endtask

    task automatic issue(int mode, int pin, logic [31:0] d);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_sel   = {3'(mode), 6'(pin)};
        cmd_data  = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_data  = ~d; // R9: data changes while idle must not matter
        model_apply(mode, pin, d);
    endtask

    initial begin
        for (int p = 0; p < NP; p++) begin
            exp_std[p] = '0;
            exp_alt[p] = '0;
        end
        cmd_valid = 1'b1;               // held during reset, must be ignored
        cmd_data  = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        cmd_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R10", "R10");        // reset state

        for (int mode = 0; mode < 8; mode++) begin
            for (int pin = 0; pin < NP; pin++) begin
                logic [31:0] d;
                d = (32'h9E37_79B9 * 32'(mode * NP + pin + 1)) ^ 32'(pin << 11);
                issue(mode, pin, d);
                check_all(tag_of(mode), "R7");
            end
        end

        // R9: long idle stretch with toggling inputs
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            cmd_sel  = 9'(i * 37);
            cmd_data = 32'h1234_5678 * 32'(i + 3);
        end
        check_all("R9", "R9");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog expired: got running exp finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule